// File: doc/BRIEF.md
# Phase-Split Latched Register File

This block is a small register file for a datapath slice. It holds sixteen 32-bit words. Two read ports, A and B, each select a word. The B address also selects the word that is written. One clock drives everything, and the two clock phases have separate jobs. While the clock is high, two output latches are open and carry the addressed words to the outputs. While the clock is low, those latches are closed and hold their value, and the storage row selected by the B address takes the incoming write data if writes are enabled.

Because of this phase split, a datapath can read an operand and write a result back to the same word within one clock period. The outputs keep showing the operand from before the write for the rest of that period. The updated word first reaches the outputs in the next high phase. The write data comes from logic outside the block and must be stable through the whole low phase.

The reset input is active low and acts on the phases. While it is low, every storage row is cleared during the low phase and both outputs read zero during the high phase.

Top module: `latch_regfile`

## Requirements
- R1: While `rst_n` is low, every stored word is cleared to zero during the low phase, and both read outputs show zero during the high phase.
- R2: While `clk` is high, `rd_data_a` is transparent: it follows the word at `addr_a`, including any change of `addr_a` within that high phase.
- R3: While `clk` is high, `rd_data_b` follows the word at `addr_b` in the same transparent way.
- R4: While `clk` is low, both read outputs keep the value they had when the clock fell, even if either address changes during the low phase.
- R5: With `wr_en` high and `rst_n` high during a low phase, the word at `addr_b` takes `wr_data`. The new value is seen on any port that selects that word in the next high phase.
- R6: With `wr_en` low, no stored word changes. The bench checks this at the ports.
- R7: When a word is read and written in the same clock period, the outputs keep showing the old value through that period's low phase. The new value appears in the next high phase.
- R8: When `addr_a` equals `addr_b`, both outputs carry the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; high phase opens the output latches, low phase opens the write path |
| rst_n | input | 1 | Active-low reset, applied on the clock phases |
| addr_a | input | 4 | Read address for port A |
| addr_b | input | 4 | Read address for port B and the write address |
| wr_en | input | 1 | Write enable for the low phase |
| wr_data | input | 32 | Word written into the row at `addr_b` |
| rd_data_a | output | 32 | Latched word from port A |
| rd_data_b | output | 32 | Latched word from port B |

## Verification
A read and a write to the same word can fall in one clock period, and this overlap is the behaviour most likely to hide a bug. The bench provokes it with directed cycles that use the same address on both ports with a write enabled. The random stream also produces it wherever an address repeats. Each output is sampled once in the high phase and once late in the low phase. Both samples must equal the word stored before the write, and the following high phase must show the new word.

// File: rtl/latch_regfile_pkg.sv
// Package: shared sizes for the latched register file.
// Assumes: the address width sets the depth as a power of two.
package latch_regfile_pkg;
    parameter int unsigned RF_DATA_W = 32;
    parameter int unsigned RF_ADDR_W = 4;
    localparam int unsigned RF_DEPTH = 1 << RF_ADDR_W;

    typedef logic [RF_DATA_W-1:0] rf_word_t;
    typedef logic [RF_ADDR_W-1:0] rf_addr_t;
endpackage

// File: rtl/rf_wr_decode.sv
// Module: turns the write address and the enable into one-hot row strobes.
// Assumes: the phase gating is done in the storage rows, not here.
module rf_wr_decode #(
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wen,
    output logic [DEPTH-1:0]  row_sel
);
    // Purpose: one row strobe per word, all low when writes are disabled.
    always_comb begin
        row_sel = '0;
        if (wen) begin
            row_sel[waddr] = 1'b1;
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Module: storage rows built as level-sensitive latches, open in the low phase.
// Assumes: row strobes and write data are stable across the whole low phase.
// Reset is taken in the low phase and clears every row.
module rf_storage #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             row_sel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DEPTH-1:0][DATA_W-1:0] rows
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DATA_W-1:0] word;

        // Purpose: capture or clear this row while the clock is low.
        always_latch begin
            if (!clk) begin
                if (!rst_n) begin
                    word <= '0;
                end else if (row_sel[g]) begin
                    word <= wdata;
                end
            end
        end

        assign rows[g] = word;
    end
endmodule

// File: rtl/rf_read_mux.sv
// Module: selects one stored word for a read port.
// Assumes: the address always falls inside the row range.
module rf_read_mux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] rows,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [DATA_W-1:0]            rword
);
    // Purpose: plain indexed select of the addressed row.
    always_comb begin
        rword = rows[raddr];
    end
endmodule

// File: rtl/rf_out_latch.sv
// Module: output latch, transparent in the high phase and holding in the low phase.
// Assumes: reset forces a zero through the open latch.
module rf_out_latch #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Purpose: pass the data while the clock is high, keep it while low.
    always_latch begin
        if (clk) begin
            dout <= rst_n ? din : '0;
        end
    end
endmodule

// File: rtl/latch_regfile.sv
// Module: top of the phase-split register file.
// The low phase writes the row at addr_b. The high phase opens both output latches.
// Assumes: wr_en, addr_b and wr_data hold steady through each low phase.
module latch_regfile
    import latch_regfile_pkg::*;
#(
    parameter int unsigned DATA_W = RF_DATA_W,
    parameter int unsigned ADDR_W = RF_ADDR_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DEPTH-1:0]             row_sel;
    logic [DEPTH-1:0][DATA_W-1:0] rows;
    logic [1:0][ADDR_W-1:0]       port_addr;
    logic [1:0][DATA_W-1:0]       port_word;
    logic [1:0][DATA_W-1:0]       port_out;

    assign port_addr[0] = addr_a;
    assign port_addr[1] = addr_b;

    rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .waddr   (addr_b),
        .wen     (wr_en),
        .row_sel (row_sel)
    );

    rf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_sel (row_sel),
        .wdata   (wr_data),
        .rows    (rows)
    );

    for (genvar p = 0; p < 2; p++) begin : g_port
        rf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
            .rows  (rows),
            .raddr (port_addr[p]),
            .rword (port_word[p])
        );
        rf_out_latch #(.DATA_W(DATA_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (port_word[p]),
            .dout  (port_out[p])
        );
    end

    assign rd_data_a = port_out[0];
    assign rd_data_b = port_out[1];
endmodule

// File: rtl/latch_regfile_chk.sv
// Module: property checker bound to the register file top.
// Assumes: inputs that feed a write are stable through the low phase.
module latch_regfile_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_a,
    input logic [ADDR_W-1:0] addr_b,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    logic              seen_fall = 1'b0;
    logic [DATA_W-1:0] a_at_fall = '0;
    logic [DATA_W-1:0] b_at_fall = '0;
    logic              prev_wr   = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [DATA_W-1:0] prev_data = '0;

    // Purpose: record the outputs and the write request at each falling edge.
    always_ff @(negedge clk) begin
        seen_fall <= 1'b1;
        a_at_fall <= rd_data_a;
        b_at_fall <= rd_data_b;
        prev_wr   <= wr_en && rst_n;
        prev_addr <= addr_b;
        prev_data <= wr_data;
    end

    assert_reset_zero_R1: assert property (@(negedge clk)
        !rst_n |-> (rd_data_a == '0 && rd_data_b == '0));

    assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_fall |-> (rd_data_a == a_at_fall && rd_data_b == b_at_fall));

    assert_write_lands_R5: assert property (@(negedge clk) disable iff (!rst_n)
        (prev_wr && addr_b == prev_addr) |-> rd_data_b == prev_data);

    assert_same_addr_R8: assert property (@(negedge clk) disable iff (!rst_n)
        (addr_a == addr_b) |-> rd_data_a == rd_data_b);
endmodule

bind latch_regfile latch_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_a    (addr_a),
    .addr_b    (addr_b),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/sim_latch_regfile.sv
// Bench: fixed-seed random traffic plus directed phase corner cases.
module sim_latch_regfile;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_a = '0;
    logic [AW-1:0] addr_b = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    logic [DW-1:0] model [DEPTH];
    int checks = 0;
    int fails = 0;

    latch_regfile u0 (
        .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
        return model[a];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One period: drive just after the rise, sample in the high and the late low phase.
    task automatic cycle(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                         input logic we, input logic [DW-1:0] wd, input string tag);
        @(posedge clk);
        #1;
        addr_a = ra; addr_b = rb; wr_en = we; wr_data = wd;
        #3;
        check({tag, " R2 high A"}, rd_data_a, expect_word(ra));
        check({tag, " R3 high B"}, rd_data_b, expect_word(rb));
        #4;
        check({tag, " R7 low A"}, rd_data_a, expect_word(ra));
        check({tag, " R7 low B"}, rd_data_b, expect_word(rb));
        if (ra == rb) check({tag, " R8 equal"}, rd_data_a, rd_data_b);
        if (we) model[rb] = wd;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;

        // R1: reset with a pending write request that must be overridden.
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #3;
        check("R1 reset out A", rd_data_a, '0);
        check("R1 reset out B", rd_data_b, '0);
        @(posedge clk);
        #1;
        rst_n = 1'b1; wr_en = 1'b0;
        for (int i = 0; i < DEPTH; i += 2) cycle(AW'(i), AW'(i + 1), 1'b0, '0, "R1 cleared");

        // R5: writes to the edge addresses.
        cycle(4'd0, 4'd15, 1'b1, 32'hDEAD_BEEF, "R5 top");
        cycle(4'd15, 4'd0, 1'b1, 32'h1234_5678, "R5 bottom");
        cycle(4'd15, 4'd0, 1'b0, '0, "R5 readback");

        // R7: read and write of the same word in one period, then the new value.
        cycle(4'd7, 4'd7, 1'b1, 32'hA5A5_0001, "R7 rmw");
        cycle(4'd7, 4'd7, 1'b1, 32'h5A5A_0002, "R7 rmw2");
        cycle(4'd7, 4'd7, 1'b0, 32'hFFFF_0000, "R7 after");

        // R6: disabled write with live data and address.
        cycle(4'd3, 4'd9, 1'b0, 32'hCAFE_CAFE, "R6 blocked");
        cycle(4'd9, 4'd9, 1'b0, '0, "R6 readback");

        // R2 and R4: address change inside the high phase, then inside the low phase.
        cycle(4'd1, 4'd2, 1'b1, 32'h0000_0222, "R4 prep");
        @(posedge clk);
        #1;
        addr_a = 4'd0; addr_b = 4'd1; wr_en = 1'b0;
        #1;
        addr_a = 4'd15;
        #2;
        check("R2 address change in high", rd_data_a, expect_word(4'd15));
        #2;
        addr_a = 4'd2; addr_b = 4'd0;
        #2;
        check("R4 hold A in low", rd_data_a, expect_word(4'd15));
        check("R4 hold B in low", rd_data_b, expect_word(4'd1));
        #4;
        check("R4 new A next high", rd_data_a, expect_word(4'd2));
        check("R4 new B next high", rd_data_b, expect_word(4'd0));

        // Random traffic for R2, R3, R5, R6, R7 and R8.
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] ra, rb;
            ra = AW'($urandom);
            rb = ($urandom % 4 == 0) ? ra : AW'($urandom);
            cycle(ra, rb, 1'($urandom), $urandom, "random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule